// File: doc/BRIEF.md
# Multi-channel ADC scan sequencer

This block drives an external successive-approximation converter. It starts each conversion with a one-cycle request that carries the channel number. It takes the 10-bit result when the converter signals completion and stores it in one of eight result slots. Three sequencing modes are supported:

- **Scan:** a continuous pass over any subset of eight inputs.
- **Dual:** a continuous alternation between two chosen inputs.
- **Step:** one channel per start event.

A run can be launched in three ways: at once by the arming write, by a timer overflow pulse, or by an edge of chosen polarity on a pin. The pin passes through a synchronizer first.

Software drives the block through a small write port. It sets the mode, the start source, the channel mask and the dual-channel pair. It arms or stops a run and acknowledges the sticky interrupt flag. Results are read back through a slot index with a registered read port. Bus bridging and the analog converter itself are outside the block.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `irq`, `busy` and `conv_start` are low.
- R2: Control register (address 0) fields:
  - Bits [1:0] hold the mode: 0 scan, 1 dual, 2 step.
  - Bits [3:2] hold the source: 0 immediate, 1 timer, 2 or 3 pin.
  - Bit 4 selects a falling edge. Bit 5 selects groups of eight. Bit 6 arms on 1 and stops on 0.

  The mask is at address 1, with bit i enabling channel i. Arming in scan or step mode with an all-zero mask leaves the block idle.
- R3: Results are written to slots in order, starting at slot 0 at each arming, wrapping after slot 7 and overwriting older values. `rd_data` shows the slot chosen by `rd_slot` one cycle after it is presented.
- R4: In dual mode (channel A at address 2 bits [2:0], B at bits [6:4]), conversions alternate A, B, A, ... so A lands in even slots and B in odd slots.
- R5: In dual mode the interrupt flag is set on every fourth result, or on every eighth when bit 5 is set.
- R6: In scan mode, channels are converted in ascending order among the enabled ones, back to back. The flag is set when the highest enabled channel completes, and the pass then restarts at the lowest.
- R7: In step mode, each completed channel sets the flag. The block then goes not-busy and waits for a new start event before converting the next enabled channel.
- R8: With the timer source, an overflow pulse starts a conversion while armed and waiting. Pulses that arrive while a conversion is running are dropped.
- R9: With the pin source, the pin passes two synchronizing flops. The chosen edge starts a conversion with `conv_start` three cycles after the pin changes. Edges during a conversion, or of the other polarity, are dropped.
- R10: With the immediate source, the arming write itself starts the first conversion, and `conv_start` rises in the following cycle. In step mode, each later arming write is the next start event.
- R11: `irq` stays set until a write of 1 to bit 0 at address 3 clears it. A set and a clear in the same cycle leave it set.
- R12: A stop write lets a conversion in flight finish and store its result, then returns to idle without setting further starts. A stop write while waiting for a start returns to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| tmr_ovf | input | 1 | Timer overflow pulse |
| trig_pin | input | 1 | Asynchronous start pin |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel for the requested conversion |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 10 | Converter result, valid with `conv_done` |
| rd_slot | input | 3 | Result slot to read |
| rd_data | output | 10 | Registered result of the chosen slot |
| irq | output | 1 | Sticky interrupt flag |
| busy | output | 1 | A conversion is in flight |

## Verification
The bench builds the block with its default parameters: eight channels, eight slots, 10-bit results and a two-flop synchronizer. It attaches a converter model with a three-cycle latency. This makes slot wrap-around reachable within a dozen conversions. Dual-mode groups of four and of eight both occur, and the three-cycle pin path is short enough to aim edges into a running conversion. The short latency also lets stop and clear writes land in the exact cycle of a completion, so the set-wins rule and stop-with-store are both exercised.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_BUSY = 2'd2
  } seq_st_e;

  localparam logic [1:0] MODE_SCAN = 2'd0;
  localparam logic [1:0] MODE_DUAL = 2'd1;
  localparam logic [1:0] MODE_STEP = 2'd2;
  localparam logic [1:0] SRC_IMM   = 2'd0;
  localparam logic [1:0] SRC_TMR   = 2'd1;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_PAIR = 2'd2;
  localparam logic [1:0] A_ACK  = 2'd3;
endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]  mask,
  input  logic [CH_W-1:0] cur,
  output logic [CH_W-1:0] first_ch,
  output logic [CH_W-1:0] next_ch,
  output logic            wraps,
  output logic            any
);
  logic found_up;
  logic [CH_W-1:0] up_ch;

  always_comb begin
    first_ch = '0;
    up_ch    = '0;
    found_up = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        first_ch = CH_W'(i);
        if (i > int'(cur)) begin
          up_ch    = CH_W'(i);
          found_up = 1'b1;
        end
      end
    end
  end

  assign any     = |mask;
  assign wraps   = !found_up;
  assign next_ch = found_up ? up_ch : first_ch;
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_hit
);
  logic [SYNC:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC-1:0], pin};
  end

  assign edge_hit = fall_sel ? (!sh[SYNC-1] && sh[SYNC])
                             : (sh[SYNC-1] && !sh[SYNC]);
endmodule

// File: rtl/adc_result_ram.sv
module adc_result_ram #(
  parameter int DEPTH = 8,
  parameter int W     = 10,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int RES_W       = 10,
  parameter int NSLOT       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CH_W        = $clog2(NCH),
  parameter int SLOT_W      = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              tmr_ovf,
  input  logic              trig_pin,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [RES_W-1:0]  rd_data,
  output logic              irq,
  output logic              busy
);
  seq_st_e st_q;
  logic [1:0]        mode_q, src_q;
  logic              pol_q, grp8_q;
  logic [NCH-1:0]    mask_q;
  logic [CH_W-1:0]   cha_q, chb_q, cur_q, chan_q;
  logic [SLOT_W-1:0] slot_q;
  logic              selb_q, stop_q, start_q, irq_q;

  logic wr_ctrl, run_set, run_clr, ack, edge_hit, trig, first_ok, done_ok, set_irq;
  logic [1:0] src_eff, mode_eff;
  logic [CH_W-1:0] first_ch, next_ch, arm_ch, next_launch, launch;
  logic wraps, any_sel;

  adc_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
    .mask(mask_q), .cur(cur_q), .first_ch(first_ch),
    .next_ch(next_ch), .wraps(wraps), .any(any_sel)
  );

  adc_trig_sync #(.SYNC(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(trig_pin), .fall_sel(pol_q), .edge_hit(edge_hit)
  );

  adc_result_ram #(.DEPTH(NSLOT), .W(RES_W), .AW(SLOT_W)) u_ram (
    .clk(clk), .we(done_ok), .waddr(slot_q), .wdata(conv_result),
    .raddr(rd_slot), .rdata(rd_data)
  );

  assign wr_ctrl  = cfg_we && (cfg_addr == A_CTRL);
  assign run_set  = wr_ctrl && cfg_wdata[6];
  assign run_clr  = wr_ctrl && !cfg_wdata[6];
  assign ack      = cfg_we && (cfg_addr == A_ACK) && cfg_wdata[0];
  assign src_eff  = wr_ctrl ? cfg_wdata[3:2] : src_q;
  assign mode_eff = wr_ctrl ? cfg_wdata[1:0] : mode_q;
  assign trig     = (src_eff == SRC_IMM) ? run_set :
                    (src_eff == SRC_TMR) ? tmr_ovf : edge_hit;
  assign first_ok = (mode_eff == MODE_DUAL) || any_sel;
  assign arm_ch   = (mode_eff == MODE_DUAL) ? cha_q : first_ch;
  assign launch   = (mode_q == MODE_DUAL) ? (selb_q ? chb_q : cha_q) : cur_q;
  assign next_launch = (mode_q == MODE_DUAL) ? (selb_q ? cha_q : chb_q) : next_ch;
  assign done_ok  = (st_q == S_BUSY) && conv_done;

  always_comb begin
    set_irq = 1'b0;
    if (done_ok) begin
      case (mode_q)
        MODE_DUAL: set_irq = (slot_q[1:0] == 2'b11) && (!grp8_q || slot_q[2]);
        MODE_STEP: set_irq = 1'b1;
        default:   set_irq = wraps;
      endcase
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_SCAN; src_q <= SRC_IMM; pol_q <= 1'b0; grp8_q <= 1'b0;
      mask_q <= '0; cha_q <= '0; chb_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_CTRL: begin
          mode_q <= cfg_wdata[1:0]; src_q <= cfg_wdata[3:2];
          pol_q  <= cfg_wdata[4];   grp8_q <= cfg_wdata[5];
        end
        A_MASK:  mask_q <= cfg_wdata[NCH-1:0];
        A_PAIR: begin
          cha_q <= cfg_wdata[CH_W-1:0];
          chb_q <= cfg_wdata[4+CH_W-1:4];
        end
        default: ;
      endcase
    end
  end

  // sequencing state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE; cur_q <= '0; chan_q <= '0; slot_q <= '0;
      selb_q <= 1'b0; stop_q <= 1'b0; start_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      irq_q   <= set_irq ? 1'b1 : (ack ? 1'b0 : irq_q);
      case (st_q)
        S_IDLE: if (run_set && first_ok) begin
          slot_q <= '0; selb_q <= 1'b0; stop_q <= 1'b0; cur_q <= arm_ch;
          if (src_eff == SRC_IMM) begin
            st_q <= S_BUSY; start_q <= 1'b1; chan_q <= arm_ch;
          end else begin
            st_q <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (run_clr) st_q <= S_IDLE;
          else if (trig) begin
            st_q <= S_BUSY; start_q <= 1'b1; chan_q <= launch;
          end
        end
        S_BUSY: begin
          if (run_clr) stop_q <= 1'b1;
          if (conv_done) begin
            slot_q <= slot_q + 1'b1;
            if (mode_q == MODE_DUAL) selb_q <= !selb_q;
            else                     cur_q  <= next_ch;
            if (stop_q || run_clr) begin
              st_q <= S_IDLE; stop_q <= 1'b0;
            end else if (mode_q == MODE_STEP) begin
              st_q <= S_WAIT;
            end else begin
              start_q <= 1'b1; chan_q <= next_launch;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign irq        = irq_q;
  assign busy       = (st_q == S_BUSY);
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_we,
  input logic [1:0]      cfg_addr,
  input logic [7:0]      cfg_wdata,
  input logic            conv_start,
  input logic [CH_W-1:0] conv_chan,
  input logic            conv_done,
  input logic            irq,
  input logic            busy,
  input logic [1:0]      mode_q,
  input logic [NCH-1:0]  mask_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq && !busy && !conv_start));

  // R2
  start_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);

  // R6
  scan_chan_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_start && mode_q != 2'd1) |-> mask_q[conv_chan]);

  // R8
  no_midconv_start_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_start && $past(busy)) |-> $past(conv_done));

  // R7
  step_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && conv_done && mode_q == 2'd2) |=> !busy);

  // R11
  irq_clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(cfg_we && cfg_addr == 2'd3 && cfg_wdata[0]));
endmodule

bind adc_scan_seq adc_scan_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .conv_start(conv_start), .conv_chan(conv_chan),
  .conv_done(conv_done), .irq(irq), .busy(busy), .mode_q(mode_q), .mask_q(mask_q)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int CLK_P = 10;
  localparam int LAT   = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0; logic [1:0] cfg_addr = '0; logic [7:0] cfg_wdata = '0;
  logic tmr_ovf = 1'b0, trig_pin = 1'b0;
  logic conv_start; logic [2:0] conv_chan;
  logic conv_done = 1'b0; logic [9:0] conv_result = '0;
  logic [2:0] rd_slot = '0; logic [9:0] rd_data;
  logic irq, busy;

  int vectors = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  adc_scan_seq dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tmr_ovf(tmr_ovf), .trig_pin(trig_pin), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result), .rd_slot(rd_slot), .rd_data(rd_data),
    .irq(irq), .busy(busy)
  );

  // converter model: fixed latency, result derived from channel and sequence number
  int cnt = 0, seqn = 0, lat_ch = 0;
  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        conv_done   <= 1'b1;
        conv_result <= 10'((lat_ch * 97 + seqn * 13) & 1023);
        seqn = seqn + 1;
      end
    end
    if (!rst && conv_start) begin cnt = LAT; lat_ch = int'(conv_chan); end
  end

  // behavioural reference: 0 idle, 1 waiting for a start, 2 converting
  int m_st, m_cur, m_slot, m_chan, m_a, m_b;
  int m_mem [8];
  bit [1:0] m_mode, m_src; bit m_pol, m_grp8, m_selb, m_stop, m_start, m_irq;
  bit [7:0] m_mask; bit [2:0] m_sh;

  always @(posedge clk) begin
    bit wc, rs, rc, ackw, edg, trg, setw, wrap, ok;
    int se, me, first, nxt, lnch;
    if (rst) begin
      m_st = 0; m_cur = 0; m_slot = 0; m_chan = 0; m_a = 0; m_b = 0;
      m_mode = 0; m_src = 0; m_pol = 0; m_grp8 = 0; m_selb = 0; m_stop = 0;
      m_start = 0; m_irq = 0; m_mask = 0; m_sh = 0;
    end else begin
      wc = cfg_we && cfg_addr == 0; rs = wc && cfg_wdata[6]; rc = wc && !cfg_wdata[6];
      ackw = cfg_we && cfg_addr == 3 && cfg_wdata[0];
      se = wc ? int'(cfg_wdata[3:2]) : int'(m_src);
      me = wc ? int'(cfg_wdata[1:0]) : int'(m_mode);
      edg = m_pol ? (!m_sh[1] && m_sh[2]) : (m_sh[1] && !m_sh[2]);
      trg = (se == 0) ? rs : (se == 1) ? tmr_ovf : edg;
      first = -1; nxt = -1;
      for (int i = 0; i < 8; i++) begin
        if (m_mask[i] && first < 0) first = i;
        if (m_mask[i] && i > m_cur && nxt < 0) nxt = i;
      end
      wrap = (nxt < 0); if (wrap) nxt = first;
      setw = 0; m_start = 0;
      if (m_st == 0) begin
        ok = (me == 1) || (first >= 0);
        if (rs && ok) begin
          m_slot = 0; m_selb = 0; m_stop = 0; m_cur = (me == 1) ? m_a : first;
          if (se == 0) begin m_st = 2; m_start = 1; m_chan = m_cur; end
          else m_st = 1;
        end
      end else if (m_st == 1) begin
        if (rc) m_st = 0;
        else if (trg) begin
          m_st = 2; m_start = 1;
          m_chan = (m_mode == 1) ? (m_selb ? m_b : m_a) : m_cur;
        end
      end else begin
        if (rc) m_stop = 1;
        if (conv_done) begin
          m_mem[m_slot] = int'(conv_result);
          if (m_mode == 1) setw = m_grp8 ? (m_slot == 7) : (m_slot % 4 == 3);
          else if (m_mode == 2) setw = 1;
          else setw = wrap;
          m_slot = (m_slot + 1) % 8;
          if (m_mode == 1) begin lnch = m_selb ? m_a : m_b; m_selb = !m_selb; end
          else begin lnch = nxt; m_cur = nxt; end
          if (m_stop) begin m_st = 0; m_stop = 0; end
          else if (m_mode == 2) m_st = 1;
          else begin m_start = 1; m_chan = lnch; end
        end
      end
      if (setw) m_irq = 1; else if (ackw) m_irq = 0;
      if (cfg_we) case (cfg_addr)
        2'd0: begin m_mode = cfg_wdata[1:0]; m_src = cfg_wdata[3:2];
                    m_pol = cfg_wdata[4]; m_grp8 = cfg_wdata[5]; end
        2'd1: m_mask = cfg_wdata;
        2'd2: begin m_a = int'(cfg_wdata[2:0]); m_b = int'(cfg_wdata[6:4]); end
        default: ;
      endcase
      m_sh = {m_sh[1:0], trig_pin};
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst && !finished) begin
      vectors = vectors + 1;
      if (conv_start !== m_start || irq !== m_irq || busy !== (m_st == 2) ||
          (conv_start && int'(conv_chan) != m_chan)) begin
        errors = errors + 1;
        $display("FAIL %s cyc %0d: start/chan/irq/busy got %b/%0d/%b/%b exp %b/%0d/%b/%b",
                 cur_req, cyc, conv_start, conv_chan, irq, busy,
                 m_start, m_chan, m_irq, (m_st == 2));
      end
    end
    if (cyc > 20000 && !finished) begin
      finished = 1'b1; errors = errors + 1;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic tpulse();
    tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
  endtask
  task automatic readback();
    for (int s = 0; s < 8; s++) begin
      rd_slot = 3'(s); @(negedge clk); vectors = vectors + 1;
      if (int'(rd_data) != m_mem[s]) begin
        errors = errors + 1;
        $display("FAIL %s slot %0d: got %0d exp %0d", cur_req, s, rd_data, m_mem[s]);
      end
    end
  endtask

  initial begin
    tick(4); rst = 1'b0; tick(3);                 // R1 reset state
    cur_req = "R2"; cfg(1, 8'h00); cfg(0, 8'h40); tick(5);   // R2 empty mask stays idle
    // R10 immediate start, R6 ascending scan on ch1,2,5,7, R3 wrap of slots
    cur_req = "R6"; cfg(1, 8'hA6); cur_req = "R10"; cfg(0, 8'h40); tick(40);
    cur_req = "R11"; cfg(3, 8'h01); tick(30);
    cur_req = "R12"; cfg(0, 8'h00); tick(10);
    cur_req = "R3"; readback();
    // R4 dual A=3 B=6, timer start, R5 groups of four then eight
    cur_req = "R4"; cfg(2, 8'h63); cfg(0, 8'h45); tick(3);
    cur_req = "R8"; tpulse(); tick(2); tpulse(); tick(25);
    cur_req = "R11"; repeat (20) cfg(3, 8'h01);
    cur_req = "R5"; tick(10); cfg(0, 8'h05); tick(10);
    cur_req = "R4"; readback();
    cur_req = "R5"; cfg(0, 8'h65); tick(2); tpulse(); tick(50);
    cfg(3, 8'h01); tick(20); cfg(0, 8'h25); tick(10); readback();
    // R7 step mode on ch0,7 with timer; R8 mid-conversion pulse dropped
    cur_req = "R7"; cfg(1, 8'h81); cfg(0, 8'h46); tick(2);
    cur_req = "R8"; tpulse(); tick(1); tpulse(); tick(10);
    cur_req = "R7"; cfg(3, 8'h01); tpulse(); tick(10); tpulse(); tick(10);
    cur_req = "R12"; cfg(0, 8'h06); tick(3);
    // R9 pin start, rising then falling polarity
    cur_req = "R9"; cfg(0, 8'h4A); tick(2);
    trig_pin = 1'b1; tick(3); trig_pin = 1'b0; tick(10);
    trig_pin = 1'b1; tick(4); trig_pin = 1'b0; tick(1); trig_pin = 1'b1; tick(10);
    cfg(0, 8'h0A); tick(3); cfg(0, 8'h5A); tick(2);
    trig_pin = 1'b0; tick(10); trig_pin = 1'b1; tick(3); trig_pin = 1'b0; tick(10);
    cfg(0, 8'h1A); tick(3);
    // R12 stop written mid-conversion on a timer-started scan
    cur_req = "R12"; cfg(1, 8'h10); cfg(0, 8'h44); tpulse(); tick(2);
    cfg(0, 8'h04); tick(10);
    cur_req = "R3"; readback();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule